// File: doc/BRIEF.md
# Trim Command Decoder with Write-Protected Preset Store

This block sits behind a serial command port and acts on one committed frame at a time. A frame carries a 2-bit page number, two control bits (recall select and write select), a 4-bit channel code and an 8-bit data byte. The block keeps twelve 8-bit channel output latches, which drive trim converters outside the block. It also keeps a small preset store of four pages by twelve bytes, with a flag that guards writes to that store.

A frame can load a latch directly, or recall one latch or all twelve from a page of the store. It can also set or clear the write guard, program one byte of the store, or read one byte back towards the serial output. A separate preset pulse reloads all twelve latches from a page chosen on its own pins.

Every operation that touches the store holds a busy flag for a parameterized number of cycles. While busy is high, the block drops any new frame or preset pulse. Recalls of all channels fill channel 1 first and channel 12 last, one channel per step.

Top module: `trim_cmd_decoder`

## Requirements
- R1: After reset, all twelve latches read 0, `busy` is 0, `wr_en` is 0 and `rd_valid` is 0. The store holds 0 in every byte.
- R2: A frame with cl=0, wr=0 and channel code 1..12 writes its data byte into latch (code-1) at the accepting edge, and `busy` stays 0.
- R3: A direct-load frame (cl=0, wr=0) whose channel code is 0, 13, 14 or 15 changes no latch.
- R4: A frame with cl=1, wr=0 and code 1..12 raises `busy` for STEP_CYC cycles. When `busy` falls, latch (code-1) holds the byte stored at that page and channel. No other latch changes.
- R5: A frame with cl=1, wr=0 and code 0 raises `busy` for 12*STEP_CYC cycles and copies the addressed page into all latches. Channel k (k = 1..12) is updated exactly k*STEP_CYC cycles after the accepting edge.
- R6: A frame with cl=1, wr=1 and code 0 sets `wr_en`, and the same with code 15 clears it. Neither raises `busy`.
- R7: A frame with cl=0, wr=1 while `wr_en` is 0 does nothing: `busy` stays 0 and the store is unchanged.
- R8: A frame with cl=0, wr=1 and code 1..12 while `wr_en` is 1 raises `busy` for PROG_CYC cycles, then stores the data byte at that page and channel. No latch changes.
- R9: A frame with cl=1, wr=1 and code 1..12 raises `busy` for STEP_CYC cycles. On the cycle `busy` falls, `rd_valid` pulses for one cycle, and `rd_word` shows 6 zero bits followed by the stored byte in its low 8 bits.
- R10: A `preset_req` pulse while idle clears `wr_en` at once. It then recalls all twelve latches from `preset_page` in channel order, with `busy` high for 12*STEP_CYC cycles. A preset pulse takes precedence over a frame offered in the same cycle.
- R11: While `busy` is 1, frames and preset pulses are ignored. This covers latches, `wr_en` and the store.
- R12: Recall or read frames with channel code 13 or 14, a recall with code 15, and a program frame with code 13 cause no change and do not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_valid | input | 1 | One-cycle pulse: frame fields are committed |
| frame_page | input | 2 | Store page of the frame |
| frame_cl | input | 1 | Recall-select control bit |
| frame_wr | input | 1 | Write-select control bit |
| frame_code | input | 4 | Channel code or sub-opcode |
| frame_data | input | 8 | Data byte |
| preset_req | input | 1 | One-cycle pulse: reload all latches from the preset page |
| preset_page | input | 2 | Page used by a preset reload |
| ch_level | output | 96 | Twelve latches, channel 1 in bits 7:0 |
| wr_en | output | 1 | Store write guard; 1 allows programming |
| busy | output | 1 | High while a store operation runs (ready is its inverse) |
| rd_valid | output | 1 | One-cycle pulse when a read result is presented |
| rd_word | output | 14 | Read result: 6 zero bits, then the byte in bits 7:0 |

## Verification
The assertions assume that `frame_valid` and `preset_req` arrive as single-cycle pulses, and that the frame fields are steady in the cycle they are committed. They also assume a change of `wr_en` can come only from an idle-cycle guard frame or preset pulse. The bench drives every pulse for exactly one clock, changing inputs on the falling edge, and keeps page numbers inside the four valid pages. It offers frames during busy windows on purpose, so the ignore rule is exercised against the same assumption.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef enum logic [2:0] {
    CMD_NONE, CMD_LOAD, CMD_RCL1, CMD_RCLALL,
    CMD_WREN, CMD_WRDIS, CMD_PROG, CMD_READ
  } cmd_e;

  typedef enum logic [1:0] {OP_RCL1, OP_RCLALL, OP_READ, OP_PROG} op_e;

  localparam int CODE_W = 4;
  localparam int PAD_W  = 6;
endpackage

// File: rtl/trim_decode.sv
module trim_decode
  import trim_pkg::*;
#(
  parameter int N_CH = 12
) (
  input  logic              cl,
  input  logic              wr,
  input  logic [CODE_W-1:0] code,
  output cmd_e              cmd
);
  localparam logic [CODE_W-1:0] MAXC = CODE_W'(N_CH);

  logic sel_ok, is_zero, is_ones;

  assign sel_ok  = (code != '0) && (code <= MAXC);
  assign is_zero = (code == '0);
  assign is_ones = (code == '1);

  always_comb begin
    cmd = CMD_NONE;
    case ({cl, wr})
      2'b00: if (sel_ok) cmd = CMD_LOAD;
      2'b01: if (sel_ok) cmd = CMD_PROG;
      2'b10: begin
        if (is_zero)     cmd = CMD_RCLALL;
        else if (sel_ok) cmd = CMD_RCL1;
      end
      default: begin
        if (is_zero)      cmd = CMD_WREN;
        else if (is_ones) cmd = CMD_WRDIS;
        else if (sel_ok)  cmd = CMD_READ;
      end
    endcase
  end
endmodule

// File: rtl/trim_store.sv
module trim_store #(
  parameter int N_PAGE = 4,
  parameter int N_CH   = 12,
  parameter int DW     = 8,
  localparam int PW    = $clog2(N_PAGE),
  localparam int CW    = $clog2(N_CH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] page,
  input  logic [CW-1:0] ch,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [N_PAGE][N_CH];

  for (genvar p = 0; p < N_PAGE; p++) begin : g_page
    for (genvar c = 0; c < N_CH; c++) begin : g_cell
      logic hit;
      assign hit = we && (page == PW'(p)) && (ch == CW'(c));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   mem[p][c] <= '0;
        else if (hit) mem[p][c] <= wdata;
      end
    end
  end

  assign rdata = mem[page][ch];
endmodule

// File: rtl/trim_latch_bank.sv
module trim_latch_bank #(
  parameter int N_CH = 12,
  parameter int DW   = 8,
  localparam int CW  = $clog2(N_CH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld,
  input  logic [CW-1:0]      ld_ch,
  input  logic [DW-1:0]      ld_val,
  output logic [N_CH*DW-1:0] q
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [DW-1:0] lat_q;
    logic          en;
    assign en = ld && (ld_ch == CW'(c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  lat_q <= '0;
      else if (en) lat_q <= ld_val;
    end
    assign q[c*DW +: DW] = lat_q;
  end
endmodule

// File: rtl/trim_seq.sv
module trim_seq
  import trim_pkg::*;
#(
  parameter int N_PAGE   = 4,
  parameter int N_CH     = 12,
  parameter int DW       = 8,
  parameter int STEP_CYC = 4,
  parameter int PROG_CYC = 20,
  localparam int PW      = $clog2(N_PAGE),
  localparam int CW      = $clog2(N_CH),
  localparam int RW      = DW + PAD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_valid,
  input  logic [PW-1:0]     frame_page,
  input  logic [CODE_W-1:0] frame_code,
  input  logic [DW-1:0]     frame_data,
  input  cmd_e              cmd,
  input  logic              preset_req,
  input  logic [PW-1:0]     preset_page,
  input  logic [DW-1:0]     st_rdata,
  output logic              st_we,
  output logic [PW-1:0]     st_page,
  output logic [CW-1:0]     st_ch,
  output logic [DW-1:0]     st_wdata,
  output logic              lat_ld,
  output logic [CW-1:0]     lat_ch,
  output logic [DW-1:0]     lat_val,
  output logic              wr_en,
  output logic              busy,
  output logic              rd_valid,
  output logic [RW-1:0]     rd_word
);
  localparam int TMAX = (PROG_CYC > STEP_CYC) ? PROG_CYC : STEP_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] T_STEP = TW'(STEP_CYC - 1);
  localparam logic [TW-1:0] T_PROG = TW'(PROG_CYC - 1);
  localparam logic [CW-1:0] LAST   = CW'(N_CH - 1);

  logic          busy_q, busy_d, wren_q, wren_d, rdv_q, rdv_d;
  op_e           op_q, op_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [CW-1:0] idx_q, idx_d, code_ch;
  logic [PW-1:0] page_q, page_d;
  logic [DW-1:0] data_q, data_d;
  logic [RW-1:0] rdw_q, rdw_d;
  logic          idle_preset, idle_frame;

  assign idle_preset = preset_req && !busy_q;
  assign idle_frame  = frame_valid && !busy_q && !preset_req;
  assign code_ch     = CW'(frame_code - 4'd1);

  always_comb begin
    busy_d  = busy_q;  op_d   = op_q;   tmr_d  = tmr_q;
    idx_d   = idx_q;   page_d = page_q; data_d = data_q;
    wren_d  = wren_q;  rdv_d  = 1'b0;   rdw_d  = rdw_q;
    st_we   = 1'b0;
    lat_ld  = 1'b0;    lat_ch = idx_q;  lat_val = st_rdata;
    if (idle_preset) begin
      busy_d = 1'b1; op_d = OP_RCLALL; idx_d = '0;
      page_d = preset_page; tmr_d = T_STEP; wren_d = 1'b0;
    end else if (idle_frame) begin
      case (cmd)
        CMD_LOAD: begin
          lat_ld = 1'b1; lat_ch = code_ch; lat_val = frame_data;
        end
        CMD_RCL1: begin
          busy_d = 1'b1; op_d = OP_RCL1; idx_d = code_ch;
          page_d = frame_page; tmr_d = T_STEP;
        end
        CMD_RCLALL: begin
          busy_d = 1'b1; op_d = OP_RCLALL; idx_d = '0;
          page_d = frame_page; tmr_d = T_STEP;
        end
        CMD_READ: begin
          busy_d = 1'b1; op_d = OP_READ; idx_d = code_ch;
          page_d = frame_page; tmr_d = T_STEP;
        end
        CMD_PROG: begin
          if (wren_q) begin
            busy_d = 1'b1; op_d = OP_PROG; idx_d = code_ch;
            page_d = frame_page; data_d = frame_data; tmr_d = T_PROG;
          end
        end
        CMD_WREN:  wren_d = 1'b1;
        CMD_WRDIS: wren_d = 1'b0;
        default: ;
      endcase
    end else if (busy_q) begin
      if (tmr_q != '0) begin
        tmr_d = tmr_q - 1'b1;
      end else begin
        case (op_q)
          OP_RCL1: begin
            lat_ld = 1'b1; busy_d = 1'b0;
          end
          OP_RCLALL: begin
            lat_ld = 1'b1;
            if (idx_q == LAST) busy_d = 1'b0;
            else begin
              idx_d = idx_q + 1'b1; tmr_d = T_STEP;
            end
          end
          OP_READ: begin
            rdv_d = 1'b1; rdw_d = {{PAD_W{1'b0}}, st_rdata}; busy_d = 1'b0;
          end
          default: begin
            st_we = 1'b1; busy_d = 1'b0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; op_q   <= OP_RCL1; tmr_q  <= '0;
      idx_q  <= '0;   page_q <= '0;      data_q <= '0;
      wren_q <= 1'b0; rdv_q  <= 1'b0;    rdw_q  <= '0;
    end else begin
      busy_q <= busy_d; op_q   <= op_d;   tmr_q  <= tmr_d;
      idx_q  <= idx_d;  page_q <= page_d; data_q <= data_d;
      wren_q <= wren_d; rdv_q  <= rdv_d;  rdw_q  <= rdw_d;
    end
  end

  assign st_page  = page_q;
  assign st_ch    = idx_q;
  assign st_wdata = data_q;
  assign wr_en    = wren_q;
  assign busy     = busy_q;
  assign rd_valid = rdv_q;
  assign rd_word  = rdw_q;
endmodule

// File: rtl/trim_cmd_decoder.sv
module trim_cmd_decoder
  import trim_pkg::*;
#(
  parameter int N_PAGE   = 4,
  parameter int N_CH     = 12,
  parameter int DW       = 8,
  parameter int STEP_CYC = 4,
  parameter int PROG_CYC = 20,
  localparam int PW      = $clog2(N_PAGE),
  localparam int CW      = $clog2(N_CH),
  localparam int RW      = DW + PAD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_valid,
  input  logic [PW-1:0]      frame_page,
  input  logic               frame_cl,
  input  logic               frame_wr,
  input  logic [CODE_W-1:0]  frame_code,
  input  logic [DW-1:0]      frame_data,
  input  logic               preset_req,
  input  logic [PW-1:0]      preset_page,
  output logic [N_CH*DW-1:0] ch_level,
  output logic               wr_en,
  output logic               busy,
  output logic               rd_valid,
  output logic [RW-1:0]      rd_word
);
  logic [1:0]    rst_sync_q;
  logic          rst_n_sync;
  cmd_e          cmd;
  logic          st_we, lat_ld;
  logic [PW-1:0] st_page;
  logic [CW-1:0] st_ch, lat_ch;
  logic [DW-1:0] st_wdata, st_rdata, lat_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  trim_decode #(.N_CH(N_CH)) u_dec (
    .cl(frame_cl), .wr(frame_wr), .code(frame_code), .cmd(cmd)
  );

  trim_seq #(
    .N_PAGE(N_PAGE), .N_CH(N_CH), .DW(DW),
    .STEP_CYC(STEP_CYC), .PROG_CYC(PROG_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n_sync),
    .frame_valid(frame_valid), .frame_page(frame_page),
    .frame_code(frame_code), .frame_data(frame_data), .cmd(cmd),
    .preset_req(preset_req), .preset_page(preset_page),
    .st_rdata(st_rdata), .st_we(st_we), .st_page(st_page),
    .st_ch(st_ch), .st_wdata(st_wdata),
    .lat_ld(lat_ld), .lat_ch(lat_ch), .lat_val(lat_val),
    .wr_en(wr_en), .busy(busy), .rd_valid(rd_valid), .rd_word(rd_word)
  );

  trim_store #(.N_PAGE(N_PAGE), .N_CH(N_CH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n_sync), .we(st_we), .page(st_page),
    .ch(st_ch), .wdata(st_wdata), .rdata(st_rdata)
  );

  trim_latch_bank #(.N_CH(N_CH), .DW(DW)) u_lat (
    .clk(clk), .rst_n(rst_n_sync), .ld(lat_ld), .ld_ch(lat_ch),
    .ld_val(lat_val), .q(ch_level)
  );
endmodule

// File: rtl/trim_cmd_decoder_chk.sv
module trim_cmd_decoder_chk #(
  parameter int RW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_valid,
  input logic          frame_cl,
  input logic          frame_wr,
  input logic [3:0]    frame_code,
  input logic          preset_req,
  input logic          wr_en,
  input logic          busy,
  input logic          rd_valid,
  input logic [RW-1:0] rd_word
);
  // R2: a direct load never starts a busy window
  assert_load_no_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && frame_valid && !preset_req && !frame_cl && !frame_wr) |=> !busy);

  // R6: the guard rises only after an idle enable frame
  assert_wren_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> $past(frame_valid && !busy && !preset_req &&
                           frame_cl && frame_wr && frame_code == 4'd0));

  // R9: read result appears as busy ends, upper bits padded with zero
  assert_read_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!busy && $past(busy)));
  assert_read_pad_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_word[RW-1:RW-6] == 6'd0));

  // R10: an idle preset clears the guard and starts busy
  assert_preset_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_req && !busy) |=> (!wr_en && busy));

  // R11: nothing arriving during busy alters the guard
  assert_busy_guard_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(wr_en));

  // R11: busy only starts from an offered frame or preset
  assert_busy_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(frame_valid || preset_req));
endmodule

bind trim_cmd_decoder trim_cmd_decoder_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .frame_valid(frame_valid),
  .frame_cl(frame_cl), .frame_wr(frame_wr), .frame_code(frame_code),
  .preset_req(preset_req), .wr_en(wr_en), .busy(busy),
  .rd_valid(rd_valid), .rd_word(rd_word)
);

// File: tb/trim_cmd_decoder_tb.sv
module trim_cmd_decoder_tb;
  localparam int STEP = 4;
  localparam int PROG = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_valid, frame_cl, frame_wr, preset_req;
  logic [1:0]  frame_page, preset_page;
  logic [3:0]  frame_code;
  logic [7:0]  frame_data;
  logic [95:0] ch_level;
  logic        wr_en, busy, rd_valid;
  logic [13:0] rd_word;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] exp_lat [12];
  logic [7:0] exp_st  [4][12];

  always #10 clk = ~clk;

  trim_cmd_decoder #(.STEP_CYC(STEP), .PROG_CYC(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid),
    .frame_page(frame_page), .frame_cl(frame_cl), .frame_wr(frame_wr),
    .frame_code(frame_code), .frame_data(frame_data),
    .preset_req(preset_req), .preset_page(preset_page),
    .ch_level(ch_level), .wr_en(wr_en), .busy(busy),
    .rd_valid(rd_valid), .rd_word(rd_word)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] pg, input logic cl, input logic wr,
                      input logic [3:0] code, input logic [7:0] d);
    @(negedge clk);
    frame_page = pg; frame_cl = cl; frame_wr = wr;
    frame_code = code; frame_data = d; frame_valid = 1'b1;
    @(negedge clk);
    frame_valid = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic check_lats(input string req);
    for (int c = 0; c < 12; c++)
      chk(ch_level[c*8 +: 8] == exp_lat[c], req, ch_level[c*8 +: 8], exp_lat[c]);
  endtask

  initial begin
    #(100000 * 20);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; frame_valid = 1'b0; preset_req = 1'b0;
    frame_page = '0; frame_cl = 1'b0; frame_wr = 1'b0;
    frame_code = '0; frame_data = '0; preset_page = '0;
    for (int c = 0; c < 12; c++) exp_lat[c] = 8'h00;
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 12; c++) exp_st[p][c] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check_lats("R1");
    chk(busy == 0, "R1 busy", busy, 0);
    chk(wr_en == 0, "R1 wr_en", wr_en, 0);
    chk(rd_valid == 0, "R1 rd_valid", rd_valid, 0);

    // R2: direct load of every channel
    for (int c = 1; c <= 12; c++) begin
      send(2'd0, 1'b0, 1'b0, 4'(c), 8'(c * 17 + 5));
      exp_lat[c-1] = 8'(c * 17 + 5);
      chk(busy == 0, "R2 busy", busy, 0);
    end
    check_lats("R2");

    // R3: ignored codes for direct load
    send(2'd0, 1'b0, 1'b0, 4'd0, 8'hA5);
    send(2'd0, 1'b0, 1'b0, 4'd13, 8'hA5);
    send(2'd0, 1'b0, 1'b0, 4'd14, 8'hA5);
    send(2'd0, 1'b0, 1'b0, 4'd15, 8'hA5);
    check_lats("R3");

    // R7: program with guard clear is dropped
    send(2'd1, 1'b0, 1'b1, 4'd3, 8'h77);
    chk(busy == 0, "R7 busy", busy, 0);
    send(2'd1, 1'b1, 1'b1, 4'd3, 8'h00);
    wait_idle(n);
    chk(rd_valid == 1, "R7 rd_valid", rd_valid, 1);
    chk(rd_word == 14'h0000, "R7 store", rd_word, 0);

    // R6: guard set and clear
    send(2'd0, 1'b1, 1'b1, 4'd0, 8'h00);
    chk(wr_en == 1 && busy == 0, "R6 enable", wr_en, 1);
    send(2'd0, 1'b1, 1'b1, 4'd15, 8'h00);
    chk(wr_en == 0 && busy == 0, "R6 disable", wr_en, 0);
    send(2'd0, 1'b1, 1'b1, 4'd0, 8'h00);
    chk(wr_en == 1, "R6 re-enable", wr_en, 1);

    // R11: frames during a busy window are dropped
    send(2'd3, 1'b0, 1'b1, 4'd12, 8'hEE);
    send(2'd0, 1'b0, 1'b0, 4'd1, 8'h3C);
    send(2'd0, 1'b1, 1'b1, 4'd15, 8'h00);
    @(negedge clk); preset_req = 1'b1; preset_page = 2'd2;
    @(negedge clk); preset_req = 1'b0;
    wait_idle(n);
    check_lats("R11");
    chk(wr_en == 1, "R11 wr_en", wr_en, 1);

    // R8: program every byte of the store
    for (int p = 0; p < 4; p++)
      for (int c = 1; c <= 12; c++) begin
        send(2'(p), 1'b0, 1'b1, 4'(c), 8'(p * 53 + c * 29 + 1));
        exp_st[p][c-1] = 8'(p * 53 + c * 29 + 1);
        wait_idle(n);
        chk(n == PROG, "R8 busy length", n, PROG);
      end
    check_lats("R8");

    // R9: read back every byte
    for (int p = 0; p < 4; p++)
      for (int c = 1; c <= 12; c++) begin
        send(2'(p), 1'b1, 1'b1, 4'(c), 8'h00);
        wait_idle(n);
        chk(n == STEP, "R9 busy length", n, STEP);
        chk(rd_valid == 1 && rd_word == {6'b0, exp_st[p][c-1]}, "R9 data",
            rd_word, {6'b0, exp_st[p][c-1]});
      end

    // R4: single-channel recall
    send(2'd2, 1'b1, 1'b0, 4'd5, 8'h00);
    wait_idle(n);
    exp_lat[4] = exp_st[2][4];
    chk(n == STEP, "R4 busy length", n, STEP);
    check_lats("R4");

    // R5: all-channel recall in order
    send(2'd1, 1'b1, 1'b0, 4'd0, 8'h00);
    repeat (5 * STEP) @(negedge clk);
    for (int c = 0; c < 5; c++) exp_lat[c] = exp_st[1][c];
    check_lats("R5 partial");
    wait_idle(n);
    chk(n == 7 * STEP, "R5 busy length", n, 7 * STEP);
    for (int c = 0; c < 12; c++) exp_lat[c] = exp_st[1][c];
    check_lats("R5");

    // R10: preset reload clears guard and wins over a frame
    chk(wr_en == 1, "R10 pre", wr_en, 1);
    @(negedge clk);
    preset_req = 1'b1; preset_page = 2'd3;
    frame_valid = 1'b1; frame_cl = 1'b0; frame_wr = 1'b0;
    frame_code = 4'd1; frame_data = 8'h11;
    @(negedge clk);
    preset_req = 1'b0; frame_valid = 1'b0;
    chk(wr_en == 0 && busy == 1, "R10 start", {wr_en, busy}, 1);
    wait_idle(n);
    chk(n == 12 * STEP, "R10 busy length", n, 12 * STEP);
    for (int c = 0; c < 12; c++) exp_lat[c] = exp_st[3][c];
    check_lats("R10");

    // R12: invalid codes on recall, read and program
    send(2'd0, 1'b0, 1'b0, 4'd2, 8'h5A);
    exp_lat[1] = 8'h5A;
    send(2'd0, 1'b1, 1'b1, 4'd0, 8'h00);
    send(2'd0, 1'b1, 1'b0, 4'd13, 8'h00);
    chk(busy == 0, "R12 recall13 busy", busy, 0);
    send(2'd0, 1'b1, 1'b0, 4'd15, 8'h00);
    chk(busy == 0, "R12 recall15 busy", busy, 0);
    send(2'd0, 1'b1, 1'b1, 4'd14, 8'h00);
    chk(busy == 0 && rd_valid == 0, "R12 read14", {busy, rd_valid}, 0);
    chk(wr_en == 1, "R12 wr_en", wr_en, 1);
    send(2'd0, 1'b0, 1'b1, 4'd13, 8'h99);
    chk(busy == 0, "R12 prog13 busy", busy, 0);
    check_lats("R12");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule